// File: doc/BRIEF.md
# Serial ADC Host Frame Controller

This block runs conversion frames against a small 8-bit serial converter over a three- or four-wire link. The link has an active-low select, a serial clock, the converter's data line coming in, and an optional configuration line going out. The serial clock is made from the system clock. Its half period is a programmable number of system cycles, which the host sets per frame. Faster rates are reached by lowering that divider; the fastest converter rate needs a serial clock of about 14.4 MHz.

There are two frame shapes. In receive-only mode a frame is 12 serial clocks long and nothing is sent to the converter. In configuration mode a frame is 16 serial clocks long. At the start of such a frame the controller sends a four-bit word: a start bit, a single-ended/differential select, an odd/sign channel select, and a padding bit. In both modes the converter first sends null bits, which the controller skips. It then returns the result, MSB first, and the result fills the last eight serial clocks of the frame. After the last result bit the controller gives no more clocks, so the converter's trailing zeros are never taken in. The result comes out with a one-cycle strobe, together with the mode and channel bits that were used.

Top module: `sadc_frame_ctrl`

## Requirements
- R1: During and straight after synchronous active-low reset the outputs are as follows: `cs_n`=1, `sclk`=0, `adc_din`=0, `busy`=0, `res_valid`=0 and `res_data`=0.
- R2: A high `start` that is sampled while `busy`=0 begins a frame, and `cs_n` is low from the next cycle. A `start` sampled while `busy`=1 has no effect on the frame in progress.
- R3: Each serial-clock half period, low or high, lasts `half_div`+1 system cycles, using the value sampled with the accepted `start`. `sclk` is low whenever `cs_n` is high, and the first half period of a frame is low.
- R4: A frame gives exactly 12 rising `sclk` edges when `cfg_mode`=0 and exactly 16 when `cfg_mode`=1. `cs_n` returns high in the same cycle that `sclk` falls after its last high phase.
- R5: `adc_dout` is sampled at each rising `sclk` edge. The samples from the last 8 rising edges of the frame form `res_data`, with the first of them in bit 7. Earlier samples (null bits), and the line outside those edges, do not affect the result.
- R6: With `cfg_mode`=1, `adc_din` is 1 from the start of the frame up to the 1st falling edge. It then holds `cfg_sgl` up to the 2nd falling edge, then `cfg_odd` up to the 3rd, and is 0 after that. With `cfg_mode`=0, and whenever `cs_n` is high, `adc_din` is 0.
- R7: `res_valid` is high for exactly one cycle per frame: the first cycle of the last high `sclk` phase. `res_data` changes only in that cycle. `res_mode` gives the frame's mode. `res_sgl` and `res_odd` give the bits that were sent, or 0 in receive-only mode.
- R8: After a frame, `cs_n` stays high with `busy`=1 for 2×(`half_div`+1) cycles, which is one serial period. With `start` held high, the next frame begins one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Frame request |
| cfg_mode | input | 1 | 0: 12-clock receive-only frame, 1: 16-clock frame with configuration word |
| cfg_sgl | input | 1 | Single-ended/differential select bit to send |
| cfg_odd | input | 1 | Odd/sign channel-select bit to send |
| half_div | input | 8 | Serial-clock half period minus one, in system cycles |
| adc_dout | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Converter select, active low |
| sclk | output | 1 | Serial clock |
| adc_din | output | 1 | Serial configuration data to the converter |
| busy | output | 1 | Frame or inter-frame gap in progress |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 8 | Conversion result |
| res_mode | output | 1 | Mode of the frame that produced the result |
| res_sgl | output | 1 | Select bit sent for the result |
| res_odd | output | 1 | Channel bit sent for the result |

## Verification
A counter that is off by one in the half-period divider stretches or shortens every `sclk` phase. This shows at the first rising edge of a frame, within `half_div`+2 cycles of `start`. A wrong frame-length or rise count gives an extra or missing clock before `cs_n` rises. It also shifts a null bit into `res_data`, or leaves the last result bit out. Both show at the end of the first frame. A stuck configuration shifter puts the wrong level on `adc_din` before the first rising edge. A gap counter that ends early shortens the high time of `cs_n` between back-to-back frames.

// File: rtl/sadc_pkg.sv
// Package: shared constants, state encoding and frame-length helper for the
// serial ADC host frame controller. Assumes an 8-bit converter result.
package sadc_pkg;

    localparam int RES_W     = 8;   // result bits returned by the converter
    localparam int CFG_W     = 4;   // start, sgl/diff, odd/sign, padding
    localparam int FRAME_RX  = 12;  // serial clocks in a receive-only frame
    localparam int FRAME_CFG = 16;  // serial clocks in a configuration frame
    localparam int CNT_W     = $clog2(FRAME_CFG + 1);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_GAP  = 2'd2
    } sadc_state_e;

    // Number of serial clocks in a frame for the given mode bit.
    function automatic logic [CNT_W-1:0] frame_len(input logic mode);
        return mode ? CNT_W'(FRAME_CFG) : CNT_W'(FRAME_RX);
    endfunction

endpackage

// File: rtl/sadc_sclk_gen.sv
// Serial clock generator. While run is high it toggles sclk every
// half_lim+1 system cycles, starting from a low phase. It reports the cycle
// whose edge makes sclk rise or fall. Assumes run drops in the cycle after the
// final falling event, which brings the counter and sclk back to rest.
module sadc_sclk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_lim,
    output logic             sclk,
    output logic             rise_evt,
    output logic             fall_evt
);

    logic [DIV_W-1:0] hcnt_q;
    logic             sclk_q;
    logic             tick;

    // Half period elapses when the counter reaches the limit.
    assign tick     = run && (hcnt_q == half_lim);
    assign rise_evt = tick && !sclk_q;
    assign fall_evt = tick &&  sclk_q;
    assign sclk     = sclk_q;

    // Half-period counter and serial clock level.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            hcnt_q <= '0;
            sclk_q <= 1'b0;
        end else if (tick) begin
            hcnt_q <= '0;
            sclk_q <= ~sclk_q;
        end else begin
            hcnt_q <= hcnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/sadc_cfg_tx.sv
// Configuration word sender. On load it presets the word (start bit first)
// when configuration mode is chosen, or all zeros otherwise. It shifts one
// bit on every falling serial clock, so each bit is stable across a rising
// edge. Assumes load and shift never coincide.
module sadc_cfg_tx #(
    parameter int CFG_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic cfg_mode,
    input  logic cfg_sgl,
    input  logic cfg_odd,
    input  logic shift,
    output logic din
);

    logic [CFG_W-1:0] word_q;
    logic [CFG_W-1:0] word_init;

    // Word layout, first bit out at the top: start, sgl, odd, then padding.
    always_comb begin
        word_init = '0;
        if (cfg_mode) begin
            word_init[CFG_W-1] = 1'b1;
            word_init[CFG_W-2] = cfg_sgl;
            word_init[CFG_W-3] = cfg_odd;
        end
    end

    // Load at frame start, shift toward the top on each falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (load) begin
            word_q <= word_init;
        end else if (shift) begin
            word_q <= {word_q[CFG_W-2:0], 1'b0};
        end
    end

    assign din = word_q[CFG_W-1];

endmodule

// File: rtl/sadc_rx_shift.sv
// Result receiver. It samples the incoming bit at each rising serial clock
// whose index falls in the last RES_W of the frame, so null bits are skipped.
// It publishes the result with a one-cycle strobe at the final edge.
// Assumes rise_idx counts rising edges from zero within the frame.
module sadc_rx_shift #(
    parameter int RES_W = 8,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise_evt,
    input  logic [CNT_W-1:0] rise_idx,
    input  logic [CNT_W-1:0] frame_n,
    input  logic             bit_in,
    output logic [RES_W-1:0] data,
    output logic             valid
);

    logic [RES_W-1:0] shreg_q;
    logic [RES_W-1:0] data_q;
    logic             valid_q;
    logic             take;
    logic             last;

    assign take = rise_evt && (rise_idx >= (frame_n - CNT_W'(RES_W)));
    assign last = rise_evt && (rise_idx == (frame_n - 1'b1));

    // Collect result bits MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
        end else if (take) begin
            shreg_q <= {shreg_q[RES_W-2:0], bit_in};
        end
    end

    // Publish the completed word with a single-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= last;
            if (last) begin
                data_q <= {shreg_q[RES_W-2:0], bit_in};
            end
        end
    end

    assign data  = data_q;
    assign valid = valid_q;

endmodule

// File: rtl/sadc_frame_ctrl.sv
// Top of the serial ADC host frame controller. The sequencer accepts a
// request when idle and latches mode, channel bits and divider. It runs the
// serial clock for 12 or 16 periods with select low, then keeps select high
// for one serial period before it goes idle. Assumes the converter changes its
// data after each falling edge, so sampling at the rising edge is safe.
module sadc_frame_ctrl
    import sadc_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cfg_mode,
    input  logic             cfg_sgl,
    input  logic             cfg_odd,
    input  logic [DIV_W-1:0] half_div,
    input  logic             adc_dout,
    output logic             cs_n,
    output logic             sclk,
    output logic             adc_din,
    output logic             busy,
    output logic             res_valid,
    output logic [RES_W-1:0] res_data,
    output logic             res_mode,
    output logic             res_sgl,
    output logic             res_odd
);

    sadc_state_e      state_q;
    logic [DIV_W-1:0] lim_q;
    logic             mode_q, sgl_q, odd_q;
    logic [CNT_W-1:0] rcnt_q, fcnt_q;
    logic [DIV_W:0]   gcnt_q;
    logic [CNT_W-1:0] frame_n;
    logic             accept, running, rise_evt, fall_evt;

    assign accept  = (state_q == ST_IDLE) && start;
    assign running = (state_q == ST_RUN);
    assign frame_n = frame_len(mode_q);

    // Frame sequencer: idle, clocking, inter-frame gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            lim_q   <= '0;
            mode_q  <= 1'b0;
            sgl_q   <= 1'b0;
            odd_q   <= 1'b0;
            rcnt_q  <= '0;
            fcnt_q  <= '0;
            gcnt_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        state_q <= ST_RUN;
                        lim_q   <= half_div;
                        mode_q  <= cfg_mode;
                        sgl_q   <= cfg_mode & cfg_sgl;
                        odd_q   <= cfg_mode & cfg_odd;
                        rcnt_q  <= '0;
                        fcnt_q  <= '0;
                    end
                end
                ST_RUN: begin
                    if (rise_evt) begin
                        rcnt_q <= rcnt_q + 1'b1;
                    end
                    if (fall_evt) begin
                        fcnt_q <= fcnt_q + 1'b1;
                        if (fcnt_q == frame_n - 1'b1) begin
                            state_q <= ST_GAP;
                            gcnt_q  <= '0;
                        end
                    end
                end
                ST_GAP: begin
                    if (gcnt_q == {lim_q, 1'b1}) begin
                        state_q <= ST_IDLE;
                    end else begin
                        gcnt_q <= gcnt_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    sadc_sclk_gen #(.DIV_W(DIV_W)) i_sclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (running),
        .half_lim (lim_q),
        .sclk     (sclk),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    sadc_cfg_tx #(.CFG_W(CFG_W)) i_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .cfg_mode (cfg_mode),
        .cfg_sgl  (cfg_sgl),
        .cfg_odd  (cfg_odd),
        .shift    (fall_evt),
        .din      (adc_din)
    );

    sadc_rx_shift #(.RES_W(RES_W), .CNT_W(CNT_W)) i_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise_evt (rise_evt),
        .rise_idx (rcnt_q),
        .frame_n  (frame_n),
        .bit_in   (adc_dout),
        .data     (res_data),
        .valid    (res_valid)
    );

    assign cs_n     = !running;
    assign busy     = (state_q != ST_IDLE);
    assign res_mode = mode_q;
    assign res_sgl  = sgl_q;
    assign res_odd  = odd_q;

endmodule

// File: rtl/sadc_frame_chk.sv
// Checker for the frame controller's port behaviour. It is bound into every
// instance of the top module.
module sadc_frame_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       cs_n,
    input logic       sclk,
    input logic       adc_din,
    input logic       busy,
    input logic       res_valid,
    input logic [7:0] res_data
);

    // R2: select falls only after a request seen while idle.
    p_cs_fall_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> ($past(start) && !$past(busy)));

    // R3: no serial clock outside a frame.
    p_sclk_rest_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    // R4: select rises just as the last high phase ends.
    p_cs_rise_after_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> ($past(sclk) && !sclk));

    // R5: the result register holds between strobes.
    p_data_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> $stable(res_data));

    // R6: configuration line quiet outside a frame.
    p_din_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !adc_din);

    // R7: strobe is a single cycle within a high phase of the frame.
    p_valid_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
    p_valid_in_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (!cs_n && sclk));

    // R8: an active frame always reports busy.
    p_busy_cover_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> busy);

endmodule

bind sadc_frame_ctrl sadc_frame_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .adc_din   (adc_din),
    .busy      (busy),
    .res_valid (res_valid),
    .res_data  (res_data)
);

// File: tb/test_sadc_frame_ctrl.sv
// Bench: a behavioural per-cycle reference, compared on every clock, plus
// directed frame measurements.
module test_sadc_frame_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0, cfg_mode = 1'b0, cfg_sgl = 1'b0, cfg_odd = 1'b0;
    logic [7:0] half_div = 8'd0;
    logic       adc_dout = 1'b0;
    logic       cs_n, sclk, adc_din, busy, res_valid, res_mode, res_sgl, res_odd;
    logic [7:0] res_data;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;   // 125 MHz

    sadc_frame_ctrl i_sadc_frame_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_mode(cfg_mode),
        .cfg_sgl(cfg_sgl), .cfg_odd(cfg_odd), .half_div(half_div),
        .adc_dout(adc_dout), .cs_n(cs_n), .sclk(sclk), .adc_din(adc_din),
        .busy(busy), .res_valid(res_valid), .res_data(res_data),
        .res_mode(res_mode), .res_sgl(res_sgl), .res_odd(res_odd)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference ----------------
    int m_st = 0, m_ph = 0, m_lim = 0, m_rises = 0, m_falls = 0, m_gap = 0, m_n = 12;
    bit m_sclk = 0, m_din = 0, m_valid = 0, m_md = 0, m_sg = 0, m_od = 0;
    bit m_bits[$];
    int m_data = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_sclk = 0; m_din = 0; m_valid = 0; m_data = 0;
            m_md = 0; m_sg = 0; m_od = 0;
        end else begin
            m_valid = 0;
            if (m_st == 0) begin
                if (start) begin
                    m_st = 1; m_lim = int'(half_div); m_ph = 0; m_sclk = 0;
                    m_rises = 0; m_falls = 0; m_md = cfg_mode;
                    m_sg = cfg_mode & cfg_sgl; m_od = cfg_mode & cfg_odd;
                    m_n = cfg_mode ? 16 : 12; m_din = cfg_mode;
                    m_bits.delete();
                end
            end else if (m_st == 1) begin
                if (m_ph == m_lim) begin
                    m_ph = 0;
                    if (!m_sclk) begin
                        m_sclk = 1; m_rises++;
                        if (m_rises > m_n - 8) m_bits.push_back(adc_dout);
                        if (m_rises == m_n) begin
                            m_data = 0;
                            foreach (m_bits[i]) m_data = ((m_data << 1) | int'(m_bits[i])) & 255;
                            m_valid = 1;
                        end
                    end else begin
                        m_sclk = 0; m_falls++;
                        m_din = (m_falls == 1) ? m_sg : (m_falls == 2) ? m_od : 1'b0;
                        if (m_falls == m_n) begin m_st = 2; m_gap = 0; end
                    end
                end else m_ph++;
            end else begin
                if (m_gap == 2 * m_lim + 1) m_st = 0; else m_gap++;
            end
        end
    end

    // Compare every output with the reference each cycle, away from the edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(cs_n == (m_st != 1), "R4 cs_n", cs_n, m_st != 1);
            chk(sclk == m_sclk, "R3 sclk", sclk, m_sclk);
            chk(adc_din == m_din, "R6 adc_din", adc_din, m_din);
            chk(busy == (m_st != 0), "R8 busy", busy, m_st != 0);
            chk(res_valid == m_valid, "R7 res_valid", res_valid, m_valid);
            chk(int'(res_data) == m_data, "R5 res_data", res_data, m_data);
            if (m_valid) begin
                chk(res_mode == m_md, "R7 res_mode", res_mode, m_md);
                chk(res_sgl == m_sg, "R7 res_sgl", res_sgl, m_sg);
                chk(res_odd == m_od, "R7 res_odd", res_odd, m_od);
            end
        end
    end

    // Random converter data every cycle, including outside the frame (R5).
    initial begin
        forever begin
            @(negedge clk);
            adc_dout = 1'($urandom_range(0, 1));
        end
    end

    // One frame with directed measurements; optionally poke start mid-frame.
    task automatic run_frame(input bit md, input bit sg, input bit od,
                             input int dv, input bit poke);
        int n = md ? 16 : 12;
        int h = dv + 1;
        int rises = 0, vcnt = 0, hrun = 0, bad_half = 0, gap = 0;
        bit prev = 0;
        bit dseq[$];
        @(negedge clk);
        cfg_mode = md; cfg_sgl = sg; cfg_odd = od; half_div = 8'(dv); start = 1;
        @(negedge clk);
        start = 0;
        chk(cs_n == 1'b0, "R2 cs low after start", cs_n, 0);
        while (!cs_n) begin
            if (sclk && !prev) begin rises++; dseq.push_back(adc_din); end
            if (sclk) hrun++;
            else if (prev) begin if (hrun != h) bad_half++; hrun = 0; end
            if (res_valid) vcnt++;
            if (poke && rises == 3) begin
                start = 1; cfg_mode = ~md; half_div = 8'(dv + 3);
            end else start = 0;
            prev = sclk;
            @(negedge clk);
        end
        start = 0;
        if (prev && hrun != h) bad_half++;
        chk(rises == n, "R4 rising edges per frame", rises, n);
        chk(bad_half == 0, "R3 high phase length", bad_half, 0);
        chk(vcnt == 1, "R7 strobes per frame", vcnt, 1);
        if (poke) chk(rises == n, "R2 start ignored while busy", rises, n);
        if (md) begin
            chk(dseq[0] == 1'b1, "R6 start bit", dseq[0], 1);
            chk(dseq[1] == sg, "R6 sgl bit", dseq[1], sg);
            chk(dseq[2] == od, "R6 odd bit", dseq[2], od);
            chk(dseq[3] == 1'b0 && dseq[4] == 1'b0, "R6 padding", dseq[3], 0);
        end else begin
            int ones = 0;
            foreach (dseq[i]) ones += int'(dseq[i]);
            chk(ones == 0, "R6 quiet in receive mode", ones, 0);
        end
        while (busy) begin
            if (cs_n) gap++;
            @(negedge clk);
        end
        chk(gap == 2 * h, "R8 gap length", gap, 2 * h);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(cs_n == 1 && sclk == 0 && adc_din == 0, "R1 link idle in reset", {cs_n, sclk, adc_din}, 4);
        chk(busy == 0 && res_valid == 0 && res_data == 0, "R1 status idle in reset", res_data, 0);
        rst_n = 1;
        @(negedge clk);
        chk(cs_n == 1 && busy == 0, "R1 idle after reset", busy, 0);

        run_frame(0, 0, 0, 0, 0);
        run_frame(1, 1, 0, 2, 0);
        run_frame(1, 0, 1, 1, 1);
        run_frame(0, 1, 1, 3, 1);
        run_frame(1, 1, 1, 0, 0);

        // Back-to-back frames with start held high (R8).
        begin
            int hi = 0;
            @(negedge clk);
            cfg_mode = 1; cfg_sgl = 0; cfg_odd = 0; half_div = 8'd1; start = 1;
            while (cs_n) @(negedge clk);
            while (!cs_n) @(negedge clk);
            while (cs_n) begin hi++; @(negedge clk); end
            chk(hi == 2 * 2 + 1, "R8 held-start select high time", hi, 5);
            start = 0;
            while (busy) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule